// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 20-bit virtual page number into a physical page number by reading two page table entries from memory. It is started when a translation lookup misses. The caller presents the virtual page number and whether the access is a write. The upper 10 bits of the page number pick an entry in the first-level table, whose base comes from a root register. That entry points to a second-level table, which always fills exactly one 4 KB page. The lower 10 bits of the page number pick the leaf entry inside that table. The 12-bit page offset is never translated, so it never enters the block.

Each table read is a one-cycle request pulse on a simple memory port. The matching response comes back later as a one-cycle valid with a 32-bit entry. The walker handles one walk at a time. It ends each walk with a one-cycle completion or a one-cycle fault. A completion carries the physical page number and the permission, dirty and use bits. A fault tells which level failed.

Entry layout (32 bits): bit 0 valid, bit 1 readable, bit 2 writable, bit 3 dirty, bits 5:4 use bits, bits 11:6 reserved, bits 31:12 page number. In a first-level entry the page number names the page that holds the second-level table.

Top module: `pt_walker`

## Requirements
- R1: While reset is high and in the first cycle after it, busy, mem_req_valid, done_valid and fault_valid are all 0.
- R2: A request presented while busy is 0 is accepted at that clock edge. In the next cycle mem_req_valid is 1 for exactly one cycle, with mem_req_addr = root_base + req_vpn[19:10]*4.
- R3: The second read is issued only in the cycle after the first-level response arrives. Its address is (first-level entry bits 31:12)*4096 + req_vpn[9:0]*4.
- R4: If the first-level entry has bit 0 clear, fault_valid pulses with fault_level = 1 and no second read is issued.
- R5: If the leaf entry has bit 0 clear, fault_valid pulses with fault_level = 2.
- R6: A read whose leaf has bit 1 clear faults with fault_level = 2. A write whose leaf has bit 2 clear faults with fault_level = 2. Otherwise the walk completes.
- R7: On success, done_valid pulses in the cycle after the leaf response. done_ppn equals leaf bits 31:12, and done_rd, done_wr, done_dirty and done_use equal leaf bits 1, 2, 3 and 5:4.
- R8: busy is 1 from the cycle after acceptance until the outcome is reported. Requests presented while busy is 1 are ignored and start no memory reads.
- R9: Each walk reports exactly one outcome, as a single-cycle pulse. done_valid and fault_valid are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a walk (taken when busy is 0) |
| req_vpn | input | 20 | Virtual page number to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| root_base | input | 32 | Physical base address of the first-level table |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | One-cycle table read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Table read data is valid |
| mem_rsp_data | input | 32 | Entry read from memory |
| done_valid | output | 1 | One-cycle successful translation |
| done_ppn | output | 20 | Translated physical page number |
| done_rd | output | 1 | Leaf allows reads |
| done_wr | output | 1 | Leaf allows writes |
| done_dirty | output | 1 | Leaf dirty bit |
| done_use | output | 2 | Leaf use bits |
| fault_valid | output | 1 | One-cycle translation fault |
| fault_level | output | 2 | Failing level: 1 or 2 |

## Verification
The assertions assume a well-behaved memory. It returns exactly one response for each read the walker issues. It never answers in the same cycle as the request, and never answers while no read is outstanding. The bench's memory model keeps to this. It latches each request and answers it exactly two cycles later. Back-to-back requests cannot occur, because the walker waits for each response before issuing the next read. The root base the bench drives is always page aligned, so every computed entry address is word aligned.

// File: rtl/pw_pkg.sv
package pw_pkg;
    localparam int VPN_W       = 20;
    localparam int L1_IDX_W    = 10;
    localparam int OFF_W       = 12;
    localparam int PA_W        = 32;
    localparam int PTE_W       = 32;
    localparam int PPN_W       = PA_W - OFF_W;
    localparam int ENTRY_SHIFT = 2;
    localparam int USE_W       = 2;

    localparam int BIT_V   = 0;
    localparam int BIT_R   = 1;
    localparam int BIT_W   = 2;
    localparam int BIT_D   = 3;
    localparam int USE_LO  = 4;

    localparam logic [1:0] LVL_ONE = 2'd1;
    localparam logic [1:0] LVL_TWO = 2'd2;

    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        logic [USE_W-1:0] use_bits;
        logic             dirty;
        logic             can_wr;
        logic             can_rd;
        logic             valid;
    } pte_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_L1,
        ST_WAIT_L2
    } walk_state_e;

    function automatic logic access_allowed(pte_t p, logic want_write);
        return want_write ? p.can_wr : p.can_rd;
    endfunction
endpackage

// File: rtl/pw_entry_addr.sv
module pw_entry_addr #(
    parameter int PA_W  = 32,
    parameter int IDX_W = 10,
    parameter int SHIFT = 2
) (
    input  logic [PA_W-1:0]  table_base,
    input  logic [IDX_W-1:0] index,
    output logic [PA_W-1:0]  entry_addr
);
    localparam int PAD_W = PA_W - IDX_W;

    logic [PA_W-1:0] index_wide;

    always_comb begin
        index_wide = {{PAD_W{1'b0}}, index};
        entry_addr = table_base + (index_wide << SHIFT);
    end
endmodule

// File: rtl/pw_pte_check.sv
module pw_pte_check
    import pw_pkg::*;
#(
    parameter int PTE_W = 32
) (
    input  logic [PTE_W-1:0] pte_word,
    input  logic             is_leaf,
    input  logic             want_write,
    output pte_t             pte,
    output logic             walk_fault
);
    logic unused_rsvd;

    always_comb begin
        pte.valid    = pte_word[BIT_V];
        pte.can_rd   = pte_word[BIT_R];
        pte.can_wr   = pte_word[BIT_W];
        pte.dirty    = pte_word[BIT_D];
        pte.use_bits = pte_word[USE_LO +: USE_W];
        pte.ppn      = pte_word[PTE_W-1 -: PPN_W];
        unused_rsvd  = ^pte_word[OFF_W-1:USE_LO+USE_W];
        walk_fault   = !pte.valid || (is_leaf && !access_allowed(pte, want_write));
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pw_pkg::*;
#(
    parameter int VPN_BITS = pw_pkg::VPN_W,
    parameter int L1_BITS  = pw_pkg::L1_IDX_W,
    parameter int ADDR_W   = pw_pkg::PA_W,
    parameter int PTE_BITS = pw_pkg::PTE_W,
    parameter int PG_OFF_W = pw_pkg::OFF_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    input  logic [VPN_BITS-1:0]          req_vpn,
    input  logic                         req_write,
    input  logic [ADDR_W-1:0]            root_base,
    output logic                         busy,
    output logic                         mem_req_valid,
    output logic [ADDR_W-1:0]            mem_req_addr,
    input  logic                         mem_rsp_valid,
    input  logic [PTE_BITS-1:0]          mem_rsp_data,
    output logic                         done_valid,
    output logic [ADDR_W-PG_OFF_W-1:0]   done_ppn,
    output logic                         done_rd,
    output logic                         done_wr,
    output logic                         done_dirty,
    output logic [USE_W-1:0]             done_use,
    output logic                         fault_valid,
    output logic [1:0]                   fault_level
);
    localparam int L2_BITS  = VPN_BITS - L1_BITS;
    localparam int PAGE_NUM = ADDR_W - PG_OFF_W;

    walk_state_e          state_q;
    logic [L2_BITS-1:0]   l2_idx_q;
    logic                 write_q;
    logic [ADDR_W-1:0]    l1_addr;
    logic [ADDR_W-1:0]    l2_addr;
    logic [ADDR_W-1:0]    l2_base;
    pte_t                 rsp_pte;
    logic                 rsp_fault;
    logic                 at_leaf;

    assign at_leaf = (state_q == ST_WAIT_L2);
    assign busy    = (state_q != ST_IDLE);
    assign l2_base = {rsp_pte.ppn, {PG_OFF_W{1'b0}}};

    pw_entry_addr #(.PA_W(ADDR_W), .IDX_W(L1_BITS), .SHIFT(ENTRY_SHIFT)) u_l1_addr (
        .table_base (root_base),
        .index      (req_vpn[VPN_BITS-1 -: L1_BITS]),
        .entry_addr (l1_addr)
    );

    pw_entry_addr #(.PA_W(ADDR_W), .IDX_W(L2_BITS), .SHIFT(ENTRY_SHIFT)) u_l2_addr (
        .table_base (l2_base),
        .index      (l2_idx_q),
        .entry_addr (l2_addr)
    );

    pw_pte_check #(.PTE_W(PTE_BITS)) u_check (
        .pte_word   (mem_rsp_data),
        .is_leaf    (at_leaf),
        .want_write (write_q),
        .pte        (rsp_pte),
        .walk_fault (rsp_fault)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= ST_IDLE;
            l2_idx_q      <= '0;
            write_q       <= 1'b0;
            mem_req_valid <= 1'b0;
            mem_req_addr  <= '0;
            done_valid    <= 1'b0;
            done_ppn      <= '0;
            done_rd       <= 1'b0;
            done_wr       <= 1'b0;
            done_dirty    <= 1'b0;
            done_use      <= '0;
            fault_valid   <= 1'b0;
            fault_level   <= '0;
        end else begin
            mem_req_valid <= 1'b0;
            done_valid    <= 1'b0;
            fault_valid   <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        l2_idx_q      <= req_vpn[L2_BITS-1:0];
                        write_q       <= req_write;
                        mem_req_valid <= 1'b1;
                        mem_req_addr  <= l1_addr;
                        state_q       <= ST_WAIT_L1;
                    end
                end
                ST_WAIT_L1: begin
                    if (mem_rsp_valid) begin
                        if (rsp_fault) begin
                            fault_valid <= 1'b1;
                            fault_level <= LVL_ONE;
                            state_q     <= ST_IDLE;
                        end else begin
                            mem_req_valid <= 1'b1;
                            mem_req_addr  <= l2_addr;
                            state_q       <= ST_WAIT_L2;
                        end
                    end
                end
                ST_WAIT_L2: begin
                    if (mem_rsp_valid) begin
                        state_q <= ST_IDLE;
                        if (rsp_fault) begin
                            fault_valid <= 1'b1;
                            fault_level <= LVL_TWO;
                        end else begin
                            done_valid <= 1'b1;
                            done_ppn   <= rsp_pte.ppn[PAGE_NUM-1:0];
                            done_rd    <= rsp_pte.can_rd;
                            done_wr    <= rsp_pte.can_wr;
                            done_dirty <= rsp_pte.dirty;
                            done_use   <= rsp_pte.use_bits;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pt_walker_checker.sv
module pt_walker_checker (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       busy,
    input logic       mem_req_valid,
    input logic       mem_rsp_valid,
    input logic       done_valid,
    input logic       fault_valid,
    input logic [1:0] fault_level
);
    p_accept_reads_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> (mem_req_valid && busy));

    p_read_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !mem_req_valid);

    p_read_only_busy_r8: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> busy);

    p_outcome_frees_r8: assert property (@(posedge clk) disable iff (rst)
        (done_valid || fault_valid) |-> !busy);

    p_outcome_after_rsp_r7: assert property (@(posedge clk) disable iff (rst)
        (done_valid || fault_valid) |-> $past(mem_rsp_valid));

    p_fault_level_r4: assert property (@(posedge clk) disable iff (rst)
        fault_valid |-> (fault_level == 2'd1 || fault_level == 2'd2));

    p_single_outcome_r9: assert property (@(posedge clk) disable iff (rst)
        !(done_valid && fault_valid));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !done_valid);
endmodule

bind pt_walker pt_walker_checker u_walker_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_rsp_valid (mem_rsp_valid),
    .done_valid    (done_valid),
    .fault_valid   (fault_valid),
    .fault_level   (fault_level)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [19:0] req_vpn = '0;
    logic        req_write = 1'b0;
    logic [31:0] root_base = 32'h0001_0000;
    logic        busy;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done_valid;
    logic [19:0] done_ppn;
    logic        done_rd, done_wr, done_dirty;
    logic [1:0]  done_use;
    logic        fault_valid;
    logic [1:0]  fault_level;

    int checks = 0;
    int fails  = 0;

    pt_walker i_pt_walker (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vpn(req_vpn),
        .req_write(req_write), .root_base(root_base), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done_valid(done_valid), .done_ppn(done_ppn), .done_rd(done_rd),
        .done_wr(done_wr), .done_dirty(done_dirty), .done_use(done_use),
        .fault_valid(fault_valid), .fault_level(fault_level)
    );

    always #10 clk = ~clk;

    // memory model and outcome monitor
    logic [31:0] pmem [logic [31:0]];
    int          cyc = 0;
    int          pend = 0;
    logic [31:0] pend_addr = '0;
    int          nreq = 0;
    logic [31:0] req_addr [4];
    int          rsp_cyc = 0;
    int          n_out = 0;
    int          n_both = 0;
    int          out_cyc = 0;
    logic        got_done = 1'b0;
    logic        got_fault = 1'b0;
    logic [1:0]  got_lvl = '0;
    logic [19:0] got_ppn = '0;
    logic [4:0]  got_flags = '0;

    function automatic logic [31:0] lookup(logic [31:0] a);
        return pmem.exists(a) ? pmem[a] : 32'h0;
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (done_valid || fault_valid) begin
            n_out++;
            out_cyc = cyc;
            if (done_valid && fault_valid) n_both++;
            got_done  = done_valid;
            got_fault = fault_valid;
            got_lvl   = fault_level;
            got_ppn   = done_ppn;
            got_flags = {done_use, done_dirty, done_wr, done_rd};
        end
        mem_rsp_valid = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = lookup(pend_addr);
                rsp_cyc       = cyc;
            end
        end
        if (mem_req_valid) begin
            if (nreq < 4) req_addr[nreq] = mem_req_addr;
            nreq++;
            pend_addr = mem_req_addr;
            pend      = 2;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // start a walk; optionally present a second request while busy
    task automatic run_walk(logic [19:0] vpn, logic wr, logic inject);
        #1;
        nreq = 0; n_out = 0; n_both = 0;
        got_done = 0; got_fault = 0;
        @(negedge clk);
        req_vpn = vpn; req_write = wr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk("R8 busy after accept", 32'(busy), 32'd1);
        chk("R2 first read issued", 32'(nreq), 32'd1);
        if (inject) begin
            req_vpn = 20'h00800; req_write = 1'b0; req_valid = 1'b1;
            @(negedge clk);
            @(negedge clk);
            req_valid = 1'b0;
        end
        for (int i = 0; i < 40 && n_out == 0; i++) @(negedge clk);
        repeat (6) @(negedge clk);
        #1;
        chk("R9 one outcome", 32'(n_out), 32'd1);
        chk("R9 never both", 32'(n_both), 32'd0);
        chk("R8 idle after outcome", 32'(busy), 32'd0);
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        chk("R1 busy in reset", 32'(busy), 32'd0);
        chk("R1 no read in reset", 32'(mem_req_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk); #1;
        chk("R1 busy after reset", 32'(busy), 32'd0);
        chk("R1 no read after reset", 32'(mem_req_valid), 32'd0);
        chk("R1 no outcome", 32'({done_valid, fault_valid}), 32'd0);
    endtask

    task automatic t_read_ok();
        run_walk(20'h00403, 1'b0, 1'b0);
        chk("R2 L1 address", req_addr[0], 32'h0001_0004);
        chk("R3 L2 address", req_addr[1], 32'h0002_000C);
        chk("R3 two reads", 32'(nreq), 32'd2);
        chk("R7 done", 32'(got_done), 32'd1);
        chk("R7 ppn", 32'(got_ppn), 32'h000AB_CDE);
        chk("R7 flags", 32'(got_flags), 32'b10111);
        chk("R7 timing", 32'(out_cyc - rsp_cyc), 32'd1);
    endtask

    task automatic t_write_ok();
        run_walk(20'hFFFFF, 1'b1, 1'b0);
        chk("R2 L1 address top", req_addr[0], 32'h0001_0FFC);
        chk("R3 L2 address top", req_addr[1], 32'h0003_0FFC);
        chk("R6 write allowed", 32'(got_done), 32'd1);
        chk("R7 ppn write", 32'(got_ppn), 32'h12345);
        chk("R7 flags write", 32'(got_flags), 32'b00010);
    endtask

    task automatic t_l1_invalid();
        run_walk(20'h00800, 1'b0, 1'b0);
        chk("R4 fault", 32'(got_fault), 32'd1);
        chk("R4 level", 32'(got_lvl), 32'd1);
        chk("R4 no second read", 32'(nreq), 32'd1);
        run_walk(20'h00C00, 1'b0, 1'b0);
        chk("R4 valid clear entry level", 32'(got_lvl), 32'd1);
        chk("R4 valid clear no read", 32'(nreq), 32'd1);
    endtask

    task automatic t_leaf_invalid();
        run_walk(20'h00405, 1'b0, 1'b0);
        chk("R5 fault", 32'(got_fault), 32'd1);
        chk("R5 level", 32'(got_lvl), 32'd2);
        chk("R5 reads", 32'(nreq), 32'd2);
    endtask

    task automatic t_perm_denied();
        run_walk(20'hFFFFF, 1'b0, 1'b0);
        chk("R6 read denied", 32'(got_fault), 32'd1);
        chk("R6 read denied level", 32'(got_lvl), 32'd2);
        run_walk(20'h00404, 1'b1, 1'b0);
        chk("R6 write denied", 32'(got_fault), 32'd1);
        chk("R6 write denied level", 32'(got_lvl), 32'd2);
        run_walk(20'h00404, 1'b0, 1'b0);
        chk("R6 read allowed", 32'(got_done), 32'd1);
        chk("R6 read allowed ppn", 32'(got_ppn), 32'h55555);
    endtask

    task automatic t_busy_reject();
        run_walk(20'h00403, 1'b0, 1'b1);
        chk("R8 busy request ignored reads", 32'(nreq), 32'd2);
        chk("R8 busy request first addr", req_addr[0], 32'h0001_0004);
        chk("R8 original walk done", 32'(got_done), 32'd1);
        chk("R8 original ppn", 32'(got_ppn), 32'hABCDE);
    endtask

    task automatic t_root_change();
        root_base = 32'h0005_0000;
        run_walk(20'h00403, 1'b0, 1'b0);
        chk("R2 new root address", req_addr[0], 32'h0005_0004);
        chk("R3 new L2 address", req_addr[1], 32'h0006_000C);
        chk("R7 new root ppn", 32'(got_ppn), 32'h77777);
        root_base = 32'h0001_0000;
    endtask

    initial begin
        pmem[32'h0001_0004] = 32'h0002_0001;
        pmem[32'h0002_000C] = 32'hABCD_E02F;
        pmem[32'h0001_0FFC] = 32'h0003_0001;
        pmem[32'h0003_0FFC] = 32'h1234_5005;
        pmem[32'h0001_000C] = 32'h0004_0006;
        pmem[32'h0002_0010] = 32'h5555_5003;
        pmem[32'h0005_0004] = 32'h0006_0001;
        pmem[32'h0006_000C] = 32'h7777_7003;
        t_reset();
        t_read_ok();
        t_write_ok();
        t_l1_invalid();
        t_leaf_invalid();
        t_perm_denied();
        t_busy_reject();
        t_root_change();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 20);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule